// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a word-addressed bank of 32-bit system control registers behind a simple synchronous register bus. Software can change most of the bank only after it opens a write-protection gate. It opens the gate by writing a 16-bit unlock key to one address and closes it by writing a different 16-bit key to another. The gate state can be read back at any time. The two key addresses always read as zero.

A one-bit control register at the base address can be written whatever the gate state. Every other configuration register loads a fixed value at reset and is only writable while the gate is open. The bank also contains a read-only status word and a hole that reads as zero and drops writes. Any offset outside the mapped ranges reads as zero.

The bus is plain and not stream-like, so it has no back-pressure. A read or write is taken in one cycle. Read data is registered and appears on the edge after the read strobe. A one-cycle `wr_reject` pulse follows any write that had no effect.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset the bank is locked, so reading offset 0xC returns 1.
- R2: A write to offset 0x8 whose low 16 bits equal 0xDF0D unlocks the bank. Any other value at 0x8 leaves the lock state unchanged.
- R3: A write to offset 0x4 whose low 16 bits equal 0x767B locks the bank. Any other value at 0x4 leaves the lock state unchanged.
- R4: Reads of offsets 0x4 and 0x8 return 0. Writes to 0xC do not change the lock state.
- R5: Offset 0x0 stores only bit 0 of the write data, in either lock state, and resets to 0.
- R6: While locked, writes to configuration registers leave their contents unchanged.
- R7: Configuration registers reset to fixed values: 0x0001A008 at 0x100, 0x104 and 0x108; 0x00014000 at 0x110, 0x114 and 0x118; 0x1F000400 at 0x120; 0x18400003 at 0x124. All other configuration words (0x11C, 0x128–0x16C, 0x300, 0x304) reset to 0.
- R8: Offset 0x10C is a read-only status word reading 0x0000003F. Writes to it are dropped even when unlocked.
- R9: Offset 0x604 reads 0 and ignores writes. Unmapped offsets also read 0.
- R10: Read data appears on `rd_data` one cycle after `rd_en`, and the low two address bits are ignored.
- R11: `wr_reject` pulses high for exactly one cycle, the cycle after a write to a configuration word while locked, or after a write to an unmapped, hole or read-only offset. Key, status and control writes never raise it.
- R12: While unlocked, configuration registers store the full 32-bit write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset into the bank |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| wr_reject | output | 1 | One-cycle pulse for a dropped write |

## Verification
The bench sends near-miss keys, such as the right low half with junk in the upper bits or the lock key sent to the unlock address. A design that compared all 32 bits, or that decoded either key at either address, would take the wrong lock state. It writes to the lock-status offset, the read-only status word and the 0x604 hole while unlocked. A design with a missing hole check would then store data there or fail to raise a reject. It confirms that the control bit changes while locked and that configuration words hold their reset values after a locked write. A lock gate applied to the wrong set of addresses shows up as a changed readback.

// File: rtl/kcb_pkg.sv
package kcb_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

  typedef enum logic [2:0] {
    K_CTRL, K_LOCK, K_UNLOCK, K_STAT, K_CFG, K_RO, K_NONE
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [4:0] idx;
  } dec_t;
endpackage

// File: rtl/kcb_decode.sv
module kcb_decode
  import kcb_pkg::*;
#(
  parameter int unsigned A_W    = AW,
  parameter int unsigned PLL_N  = 8,
  parameter int unsigned CLK_N  = 20
) (
  input  logic [A_W-1:0] word_addr,
  output dec_t           dec
);
  localparam int unsigned PLL_BASE = 12'h100 >> 2;
  localparam int unsigned CLK_BASE = PLL_BASE + PLL_N;
  localparam int unsigned RO_IDX   = 3;
  localparam int unsigned APU0     = 12'h300 >> 2;
  localparam int unsigned HOLE     = 12'h604 >> 2;

  int unsigned w;
  always_comb begin
    w        = 32'(word_addr);
    dec.kind = K_NONE;
    dec.idx  = '0;
    if (w == 0)       dec.kind = K_CTRL;
    else if (w == 1)  dec.kind = K_LOCK;
    else if (w == 2)  dec.kind = K_UNLOCK;
    else if (w == 3)  dec.kind = K_STAT;
    else if (w >= PLL_BASE && w < PLL_BASE + PLL_N) begin
      dec.idx  = 5'(w - PLL_BASE);
      dec.kind = (w - PLL_BASE == RO_IDX) ? K_RO : K_CFG;
    end else if (w >= CLK_BASE && w < CLK_BASE + CLK_N) begin
      dec.idx  = 5'(w - PLL_BASE);
      dec.kind = K_CFG;
    end else if (w == APU0 || w == APU0 + 1) begin
      dec.idx  = 5'(PLL_N + CLK_N + (w - APU0));
      dec.kind = K_CFG;
    end else if (w == HOLE) begin
      dec.kind = K_NONE;
    end
  end
endmodule

// File: rtl/kcb_lock.sv
module kcb_lock
  import kcb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  kind_e       kind,
  input  logic [15:0] key,
  output logic        locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b1;
    else if (wr_en && kind == K_LOCK && key == LOCK_KEY) locked <= 1'b1;
    else if (wr_en && kind == K_UNLOCK && key == UNLOCK_KEY) locked <= 1'b0;
  end

  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_LOCK && key == LOCK_KEY) |=> locked);
  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_UNLOCK && key == UNLOCK_KEY) |=> !locked);
  // R4
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_STAT) |=> $stable(locked));
endmodule

// File: rtl/kcb_regfile.sv
module kcb_regfile
  import kcb_pkg::*;
#(
  parameter int unsigned N = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [4:0]    widx,
  input  logic [DW-1:0] wdata,
  input  logic [4:0]    ridx,
  output logic [DW-1:0] rdata
);
  function automatic logic [DW-1:0] rst_val(input int unsigned i);
    case (i)
      0, 1, 2:   return 32'h0001A008;
      3:         return 32'h0000003F;
      4, 5, 6:   return 32'h00014000;
      8:         return 32'h1F000400;
      9:         return 32'h18400003;
      default:   return '0;
    endcase
  endfunction

  logic [DW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= rst_val(g);
      else if (we && widx == 5'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = (32'(ridx) < N) ? regs[ridx] : '0;
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import kcb_pkg::*;
#(
  parameter int unsigned PLL_N = 8,
  parameter int unsigned CLK_N = 20,
  parameter int unsigned AUX_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          wr_reject
);
  localparam int unsigned NREG = PLL_N + CLK_N + AUX_N;

  dec_t          dec;
  logic          locked;
  logic          ctrl_bit;
  logic [DW-1:0] cfg_q;
  logic          cfg_we;

  kcb_decode #(.A_W(AW-2), .PLL_N(PLL_N), .CLK_N(CLK_N)) u_dec (
    .word_addr(addr[AW-1:2]), .dec(dec));

  kcb_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(dec.kind),
    .key(wr_data[15:0]), .locked(locked));

  assign cfg_we = wr_en && dec.kind == K_CFG && !locked;

  kcb_regfile #(.N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(dec.idx), .wdata(wr_data),
    .ridx(dec.idx), .rdata(cfg_q));

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_bit <= 1'b0;
    else if (wr_en && dec.kind == K_CTRL) ctrl_bit <= wr_data[0];
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (dec.kind)
      K_CTRL:       rd_mux = {31'b0, ctrl_bit};
      K_STAT:       rd_mux = {31'b0, locked};
      K_CFG, K_RO:  rd_mux = cfg_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data   <= '0;
      wr_reject <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      wr_reject <= wr_en && ((dec.kind == K_CFG && locked) ||
                             dec.kind == K_RO || dec.kind == K_NONE);
    end
  end

  // R11
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject && !$past(wr_en)) |-> 1'b0);
  // R11
  ctrl_no_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.kind == K_CTRL) |=> !wr_reject);
  // R5
  ctrl_any_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.kind == K_CTRL) |=> ctrl_bit == $past(wr_data[0]));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_keyed_ctrl_bank.sv
module sim_keyed_ctrl_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        wr_reject;

  always #4 clk = ~clk;

  keyed_ctrl_bank u0 (.*);

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit rej, string tag);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
    check(tag, {31'b0, wr_reject}, {31'b0, rej});
  endtask

  // driver: pushes expected value, monitor pops after the data edge
  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    addr = a; rd_en = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #2;
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    check("R11 reset", {31'b0, wr_reject}, 0);
    rd(12'h00C, 1, "R1 locked at reset");
    rd(12'h000, 0, "R5 ctrl reset");
    rd(12'h100, 32'h0001A008, "R7 pll0");
    rd(12'h108, 32'h0001A008, "R7 pll2");
    rd(12'h114, 32'h00014000, "R7 cfg1");
    rd(12'h120, 32'h1F000400, "R7 clk0");
    rd(12'h124, 32'h18400003, "R7 clk1");
    rd(12'h300, 0, "R7 aux0");
    rd(12'h10C, 32'h3F, "R8 status");
    // locked writes
    wr(12'h100, 32'h12345678, 1, "R11 locked reject");
    rd(12'h100, 32'h0001A008, "R6 locked write dropped");
    wr(12'h000, 32'hFFFFFFFF, 0, "R11 ctrl no reject");
    rd(12'h000, 1, "R5 ctrl while locked");
    // near-miss keys
    wr(12'h008, 32'h0000767B, 0, "R11 key no reject");
    rd(12'h00C, 1, "R2 wrong key stays locked");
    wr(12'h004, 32'h0000DF0D, 0, "R11 key no reject");
    rd(12'h00C, 1, "R3 unlock key at lock addr");
    wr(12'h008, 32'hABCDDF0D, 0, "R2 unlock");
    rd(12'h00C, 0, "R2 unlocked (upper bits ignored)");
    rd(12'h004, 0, "R4 lock reads zero");
    rd(12'h008, 0, "R4 unlock reads zero");
    wr(12'h00C, 32'h1, 0, "R4 stat write");
    rd(12'h00C, 0, "R4 stat write ignored");
    // unlocked
    wr(12'h104, 32'hCAFEF00D, 0, "R12 write");
    rd(12'h104, 32'hCAFEF00D, "R12 readback");
    wr(12'h304, 32'h89ABCDEF, 0, "R12 aux write");
    rd(12'h307, 32'h89ABCDEF, "R10 low addr bits ignored");
    wr(12'h10C, 32'h0, 1, "R11 ro reject");
    rd(12'h10C, 32'h3F, "R8 ro unchanged");
    wr(12'h604, 32'hFFFF, 1, "R11 hole reject");
    rd(12'h604, 0, "R9 hole zero");
    rd(12'hF00, 0, "R9 unmapped zero");
    wr(12'h000, 32'hFFFFFFFE, 0, "R5 ctrl write");
    rd(12'h000, 0, "R5 only bit0");
    wr(12'h004, 32'h5555767B, 0, "R3 relock");
    rd(12'h00C, 1, "R3 relocked");
    wr(12'h104, 32'h0, 1, "R11 locked again");
    rd(12'h104, 32'hCAFEF00D, "R6 held after relock");
    // R10 timing: data not yet present at the read edge
    addr = 12'h120; rd_en = 1; #1;
    check("R10 not combinational", rd_data, 32'hCAFEF00D);
    exp_q.push_back(32'h1F000400); tag_q.push_back("R10 latency");
    @(posedge clk); #1; rd_en = 0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule